// File: doc/BRIEF.md
# Standby/Run Power Mode Controller

This block sequences a system between two stable power modes, standby and run. It drives an ON/OFF level that enables the system supply and a timed reset pulse that restarts the system and clears the serial bus engine. Which events may wake the system, or restart it, depends on the mode. In standby a set of wake sources brings the system up. In run a different set of fault sources issues a reset pulse. A host can turn the supply off or drop the system back to standby through a small control write.

Every reset pulse locks out the gated event inputs until the host sends an explicit re-enable strobe. The watchdog and undervoltage inputs are never locked out. A watchdog that misses five times in a row, with no valid kick in between, powers the system down into standby. So does a host that fails to read after a change indication. The reset pulse width is timed in milliseconds from a prescaled system clock and has four selectable lengths.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in standby with `on_off` low, `rst_pulse` low, `in_locked` low, and the pulse width code set to 3 (20 ms).
- R2: In standby, a one-cycle `alarm`, `dev_rst`, `imp_det` or `osc_fault`, or any change of `port_in` from its value in the previous cycle, moves the block to run. On that edge it raises `on_off` and starts a reset pulse.
- R3: `bus_clr` is high for exactly the first cycle of every reset pulse.
- R4: A reset pulse stays high for N × `TICK_DIV` clock cycles. N is 1, 5, 10 or 20 ms for width codes 0, 1, 2 and 3.
- R5: Every reset pulse sets `in_locked`. While locked, `osc_fault`, `bus_miss`, `ext_rst` and `read_miss` have no effect. A `cmd_en_rst` strobe clears the lock.
- R6: In run, `wd_miss`, or an unlocked `osc_fault`, `bus_miss` or `ext_rst`, starts a reset pulse. In run, `alarm`, `dev_rst`, `imp_det` and `port_in` changes have no effect.
- R7: In run, `cmd_wr` loads `cmd_ctrl`. Bit 1 sets the `on_off` level, bits 3:2 set the width code, and bit 0 = 1 enters standby with `on_off` low. In standby, `cmd_wr` is ignored.
- R8: In run, each of the first four consecutive `wd_miss` pulses gives a reset pulse. The fifth enters standby with `on_off` low. A `wd_kick` clears the miss count.
- R9: In standby, `wd_miss`, `wd_kick`, `uv_evt`, `ext_rst`, `bus_miss` and `read_miss` have no effect.
- R10: In run while unlocked, `read_miss` enters standby with `on_off` low.
- R11: In run, `uv_evt` drives `on_off` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | PORT_W | Monitored input port, any change is an event |
| imp_det | input | 1 | Impedance detect event |
| dev_rst | input | 1 | Device reset event |
| alarm | input | 1 | Alarm timer event |
| uv_evt | input | 1 | Undervoltage timer event |
| osc_fault | input | 1 | Oscillator fault event |
| wd_kick | input | 1 | Valid watchdog trigger |
| wd_miss | input | 1 | Failed watchdog trigger |
| ext_rst | input | 1 | External reset request |
| bus_miss | input | 1 | Missed bus communication |
| read_miss | input | 1 | Missed read after a change indication |
| cmd_wr | input | 1 | Control write strobe |
| cmd_ctrl | input | 4 | Control value: bit0 standby, bit1 on level, bits 3:2 width code |
| cmd_en_rst | input | 1 | Re-enable strobe for the gated inputs |
| on_off | output | 1 | Supply enable level |
| rst_pulse | output | 1 | Timed reset pulse |
| bus_clr | output | 1 | One-cycle bus interface clear |
| run_mode | output | 1 | High in run, low in standby |
| in_locked | output | 1 | Gated inputs are locked out |

## Verification
The width assertion assumes that no standby entry cuts a pulse short. It also assumes that a fresh pulse can restart only at a marked start, because the measured count restarts on `bus_clr`. The lock-hold property assumes that `cmd_en_rst` is the only way out of lockout apart from standby entry. The stimulus applies every event as a single-cycle strobe away from the clock edge. It lets each pulse finish before the next event, so no fifth watchdog miss or standby command ever lands inside a running pulse.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef logic [1:0] width_code_t;

  localparam int unsigned MS_W = 5;
  localparam width_code_t DEF_CODE = 2'd3;

  function automatic logic [MS_W-1:0] code_to_ms(input width_code_t c);
    case (c)
      2'd0:    return MS_W'(1);
      2'd1:    return MS_W'(5);
      2'd2:    return MS_W'(10);
      default: return MS_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/pmc_chg.sv
module pmc_chg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic         chg
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  assign chg = (din != prev_q);
endmodule

// File: rtl/pmc_pulse.sv
module pmc_pulse #(
  parameter int unsigned TICK_DIV = 50000,
  parameter int unsigned MS_W     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic [MS_W-1:0] load_ms,
  output logic            active
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [MS_W-1:0]  ms_q, ms_n;
  logic             act_q, act_n;

  always_comb begin
    pre_n = pre_q;
    ms_n  = ms_q;
    act_n = act_q;
    if (abort) begin
      act_n = 1'b0;
      pre_n = '0;
      ms_n  = '0;
    end else if (start) begin
      act_n = 1'b1;
      pre_n = '0;
      ms_n  = load_ms;
    end else if (act_q) begin
      if (pre_q == PRE_LAST) begin
        pre_n = '0;
        if (ms_q == MS_W'(1)) begin
          act_n = 1'b0;
          ms_n  = '0;
        end else begin
          ms_n = ms_q - MS_W'(1);
        end
      end else begin
        pre_n = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      act_q <= 1'b0;
    end else begin
      pre_q <= pre_n;
      ms_q  <= ms_n;
      act_q <= act_n;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/pmc_strikes.sv
module pmc_strikes #(
  parameter int unsigned STRIKES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic kick,
  input  logic miss,
  output logic last
);
  localparam int unsigned CW = $clog2(STRIKES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STRIKES - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign last = en && miss && !kick && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_n = cnt_q;
    if (clr || !en)    cnt_n = '0;
    else if (kick)     cnt_n = '0;
    else if (last)     cnt_n = '0;
    else if (miss)     cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned TICK_DIV = 50000,
  parameter int unsigned STRIKES  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_in,
  input  logic              imp_det,
  input  logic              dev_rst,
  input  logic              alarm,
  input  logic              uv_evt,
  input  logic              osc_fault,
  input  logic              wd_kick,
  input  logic              wd_miss,
  input  logic              ext_rst,
  input  logic              bus_miss,
  input  logic              read_miss,
  input  logic              cmd_wr,
  input  logic [3:0]        cmd_ctrl,
  input  logic              cmd_en_rst,
  output logic              on_off,
  output logic              rst_pulse,
  output logic              bus_clr,
  output logic              run_mode,
  output logic              in_locked
);
  logic        run_q, run_n;
  logic        on_q, on_n;
  logic        lock_q, lock_n;
  logic        clr_q;
  width_code_t width_q, width_n;
  logic        start, go_sb, chg, strike_last, pulse_act;

  pmc_chg #(.W(PORT_W)) u_chg (
    .clk(clk), .rst_n(rst_n), .din(port_in), .chg(chg)
  );

  pmc_strikes #(.STRIKES(STRIKES)) u_strk (
    .clk(clk), .rst_n(rst_n), .en(run_q), .clr(go_sb),
    .kick(wd_kick), .miss(wd_miss), .last(strike_last)
  );

  pmc_pulse #(.TICK_DIV(TICK_DIV), .MS_W(MS_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(go_sb),
    .load_ms(code_to_ms(width_n)), .active(pulse_act)
  );

  always_comb begin
    run_n   = run_q;
    on_n    = on_q;
    lock_n  = lock_q;
    width_n = width_q;
    start   = 1'b0;
    go_sb   = 1'b0;
    if (!run_q) begin
      if (alarm || dev_rst || chg || imp_det || osc_fault) begin
        run_n  = 1'b1;
        on_n   = 1'b1;
        lock_n = 1'b1;
        start  = 1'b1;
      end
    end else begin
      go_sb = strike_last || (!lock_q && read_miss) || (cmd_wr && cmd_ctrl[0]);
      if (go_sb) begin
        run_n  = 1'b0;
        on_n   = 1'b0;
        lock_n = 1'b0;
      end else begin
        if (cmd_wr) begin
          on_n    = cmd_ctrl[1];
          width_n = cmd_ctrl[3:2];
        end
        if (uv_evt)     on_n   = 1'b1;
        if (cmd_en_rst) lock_n = 1'b0;
        if (wd_miss || (!lock_q && (osc_fault || bus_miss || ext_rst))) begin
          start  = 1'b1;
          lock_n = 1'b1;
          on_n   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      on_q    <= 1'b0;
      lock_q  <= 1'b0;
      width_q <= DEF_CODE;
      clr_q   <= 1'b0;
    end else begin
      run_q   <= run_n;
      on_q    <= on_n;
      lock_q  <= lock_n;
      width_q <= width_n;
      clr_q   <= start;
    end
  end

  assign on_off    = on_q;
  assign rst_pulse = pulse_act;
  assign bus_clr   = clr_q;
  assign run_mode  = run_q;
  assign in_locked = lock_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run_mode,
  input logic        on_off,
  input logic        rst_pulse,
  input logic        bus_clr,
  input logic        in_locked,
  input logic        cmd_en_rst,
  input width_code_t width_code
);
  logic [31:0] pcnt;
  width_code_t cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      cap  <= DEF_CODE;
    end else if (rst_pulse) begin
      if (bus_clr) begin
        pcnt <= 32'd1;
        cap  <= width_code;
      end else begin
        pcnt <= pcnt + 32'd1;
      end
    end
  end

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_mode |-> (!on_off && !rst_pulse && !in_locked));

  assert_clr_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> bus_clr);

  assert_clr_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clr |-> rst_pulse);

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rst_pulse) && run_mode) |-> (pcnt == 32'(code_to_ms(cap)) * TICK_DIV));

  assert_lock_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> (in_locked && run_mode));

  assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_locked && run_mode && !cmd_en_rst) |=> (in_locked || !run_mode));
endmodule

bind pwr_mode_ctrl pmc_checker #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .on_off(on_off),
  .rst_pulse(rst_pulse), .bus_clr(bus_clr), .in_locked(in_locked),
  .cmd_en_rst(cmd_en_rst), .width_code(width_q)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk, rst_n;
  logic [7:0] port_in;
  logic imp_det, dev_rst, alarm, uv_evt, osc_fault, wd_kick, wd_miss;
  logic ext_rst, bus_miss, read_miss, cmd_wr, cmd_en_rst;
  logic [3:0] cmd_ctrl;
  logic on_off, rst_pulse, bus_clr, run_mode, in_locked;

  int compared = 0, mismatched = 0;
  int exp_q[$];
  logic prev_p = 1'b0;
  int plen = 0;
  bit done = 0;

  pwr_mode_ctrl #(.PORT_W(8), .TICK_DIV(DIV), .STRIKES(5)) uut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .imp_det(imp_det),
    .dev_rst(dev_rst), .alarm(alarm), .uv_evt(uv_evt), .osc_fault(osc_fault),
    .wd_kick(wd_kick), .wd_miss(wd_miss), .ext_rst(ext_rst),
    .bus_miss(bus_miss), .read_miss(read_miss), .cmd_wr(cmd_wr),
    .cmd_ctrl(cmd_ctrl), .cmd_en_rst(cmd_en_rst), .on_off(on_off),
    .rst_pulse(rst_pulse), .bus_clr(bus_clr), .run_mode(run_mode),
    .in_locked(in_locked)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int act, input int expv, input string what);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // monitor: measures every reset pulse and pops the expected length
  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_pulse && !prev_p) begin
        plen = 1;
        chk(int'(bus_clr), 1, "R3 bus_clr at pulse start");
      end else if (rst_pulse) begin
        plen++;
      end else if (prev_p) begin
        if (exp_q.size() == 0) begin
          compared++;
          mismatched++;
          $display("FAIL R5/R6/R9 unexpected pulse: actual %0d expected 0", plen);
        end else begin
          chk(plen, exp_q.pop_front(), "R4 pulse length");
        end
      end
      prev_p = rst_pulse;
    end
  end

  task automatic expect_pulse(input int ms);
    exp_q.push_back(ms * DIV);
  endtask

  task automatic fire(input string nm);
    @(negedge clk);
    case (nm)
      "port":  port_in = port_in ^ 8'h01;
      "imp":   imp_det = 1'b1;
      "dev":   dev_rst = 1'b1;
      "alarm": alarm = 1'b1;
      "uv":    uv_evt = 1'b1;
      "osc":   osc_fault = 1'b1;
      "kick":  wd_kick = 1'b1;
      "miss":  wd_miss = 1'b1;
      "ext":   ext_rst = 1'b1;
      "bus":   bus_miss = 1'b1;
      "read":  read_miss = 1'b1;
      "en":    cmd_en_rst = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    {imp_det, dev_rst, alarm, uv_evt, osc_fault, wd_kick, wd_miss} = '0;
    {ext_rst, bus_miss, read_miss, cmd_en_rst} = '0;
  endtask

  task automatic cmd(input logic [3:0] v);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_ctrl = v;
    @(negedge clk);
    cmd_wr = 1'b0;
    cmd_ctrl = '0;
  endtask

  task automatic settle();
    while (rst_pulse) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    port_in = '0;
    {imp_det, dev_rst, alarm, uv_evt, osc_fault, wd_kick, wd_miss} = '0;
    {ext_rst, bus_miss, read_miss, cmd_wr, cmd_en_rst} = '0;
    cmd_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(run_mode), 0, "R1 reset run_mode");
    chk(int'(on_off), 0, "R1 reset on_off");
    chk(int'(rst_pulse), 0, "R1 reset rst_pulse");
    chk(int'(in_locked), 0, "R1 reset in_locked");

    // wake from standby via port change, default 20 ms width
    expect_pulse(20);
    fire("port");
    settle();
    chk(int'(run_mode), 1, "R2 port change wakes");
    chk(int'(on_off), 1, "R2 on_off after wake");
    chk(int'(in_locked), 1, "R5 lock after pulse");

    // locked: external reset ignored
    fire("ext");
    settle();
    chk(int'(in_locked), 1, "R5 lock held");
    chk(int'(run_mode), 1, "R5 still run");

    // width codes through run reset sources
    fire("en");
    chk(int'(in_locked), 0, "R5 re-enable clears lock");
    cmd(4'b0010);
    expect_pulse(1);
    fire("ext");
    settle();
    fire("en");
    cmd(4'b0110);
    expect_pulse(5);
    fire("bus");
    settle();
    fire("en");
    cmd(4'b1010);
    expect_pulse(10);
    fire("osc");
    settle();
    fire("en");

    // standby wake sources have no effect in run
    fire("alarm");
    fire("dev");
    fire("imp");
    fire("port");
    settle();
    chk(int'(run_mode), 1, "R6 run ignores wake sources");
    chk(int'(in_locked), 0, "R6 no lock from wake sources");

    // host on/off level and undervoltage
    cmd(4'b1000);
    chk(int'(on_off), 0, "R7 host clears on_off");
    chk(int'(run_mode), 1, "R7 stays run");
    fire("uv");
    chk(int'(on_off), 1, "R11 uv_evt raises on_off");

    // watchdog strikes, width code 0
    cmd(4'b0010);
    for (int i = 0; i < 4; i++) begin
      expect_pulse(1);
      fire("miss");
      settle();
    end
    fire("kick");
    for (int i = 0; i < 4; i++) begin
      expect_pulse(1);
      fire("miss");
      settle();
    end
    chk(int'(run_mode), 1, "R8 kick cleared count");
    fire("miss");
    settle();
    chk(int'(run_mode), 0, "R8 fifth miss enters standby");
    chk(int'(on_off), 0, "R8 on_off low");

    // standby ignores run-only sources and host writes
    fire("miss");
    fire("kick");
    fire("uv");
    fire("ext");
    fire("bus");
    fire("read");
    cmd(4'b1110);
    settle();
    chk(int'(run_mode), 0, "R9 standby ignores run sources");
    chk(int'(on_off), 0, "R9 on_off stays low");

    // wake by alarm: width must still be code 0 (standby write ignored)
    expect_pulse(1);
    fire("alarm");
    settle();
    chk(int'(run_mode), 1, "R2 alarm wakes");
    fire("en");
    cmd(4'b0001);
    chk(int'(run_mode), 0, "R7 bit0 enters standby");
    chk(int'(on_off), 0, "R7 standby on_off low");

    // wake by oscillator fault, then missed read
    expect_pulse(1);
    fire("osc");
    settle();
    chk(int'(run_mode), 1, "R2 osc_fault wakes");
    fire("read");
    chk(int'(run_mode), 1, "R5 locked read_miss ignored");
    fire("en");
    fire("read");
    chk(int'(run_mode), 0, "R10 read_miss enters standby");
    chk(int'(on_off), 0, "R10 on_off low");

    // device reset and impedance wakes
    expect_pulse(1);
    fire("dev");
    settle();
    chk(int'(run_mode), 1, "R2 dev_rst wakes");
    cmd(4'b0001);
    expect_pulse(1);
    fire("imp");
    settle();
    chk(int'(run_mode), 1, "R2 imp_det wakes");
    chk(exp_q.size(), 0, "R4 all expected pulses seen");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule